// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block corrects an 8-bit accumulator after a binary add or subtract so that the result becomes valid decimal again. Two forms are supported. The packed form holds two decimal digits in one byte. The unpacked (ASCII) form holds one digit in the low nibble and carries into or borrows from a second accumulator byte. The caller presents the low accumulator byte, the high accumulator byte, the incoming auxiliary-carry and carry flags and a 2-bit operation select. The block returns the corrected bytes and the new auxiliary-carry and carry flags.

The correction is made one nibble at a time. The low nibble is fixed first, and that step decides the auxiliary-carry flag. The decision on the high nibble then uses the low step's outcome and the incoming carry, and it decides the carry flag. With the default settings the result is held in a register and is due one clock after a valid input. A build-time parameter can remove the register, which leaves a purely combinational path.

Top module: `bcdadj_top`

## Requirements
- R1: Packed add (opSel = 2'b00): when the low nibble of accLo is above 9 or auxIn is 1, 06h is added and auxOut is 1; otherwise nothing is added at this step and auxOut is 0 (8Eh gives 94h).
- R2: Packed add, high step: 60h is also added and carryOut is 1 when the high nibble after the low step is above 9, or the low step carried out of bit 7, or carryIn is 1; otherwise carryOut is 0 (D1h with auxIn=1 gives 37h with carryOut=1; FAh gives 60h).
- R3: Packed subtract (opSel = 2'b01): 06h is subtracted with auxOut=1 when the low nibble is above 9 or auxIn is 1. 60h is subtracted with carryOut=1 when the original accLo is above 99h or carryIn is 1. Each flag is 0 when its step is not taken.
- R4: In the packed modes, when neither step applies, resLo equals accLo and both flags are 0. In both packed modes resHi equals accHi.
- R5: Unpacked add (opSel = 2'b10): when the low nibble is above 9 or auxIn is 1, accLo gets 6 added, accHi gets 1 added, and both flags are 1. Otherwise accHi passes through and both flags are 0, whatever carryIn is. In every case resLo[7:4] is 0.
- R6: Unpacked subtract (opSel = 2'b11): under the same condition as R5, accLo has 6 subtracted, accHi has 1 subtracted, and both flags are 1. Otherwise both flags are 0. In every case resLo[7:4] is 0.
- R7: With the output register built (the default), the results and outValid appear on the clock edge after inValid is sampled high. While inValid is low, outValid is 0 and the data outputs keep their last values.
- R8: While rstN is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The inputs hold an operation to adjust |
| opSel | input | 2 | Bit 1 selects unpacked, bit 0 selects subtract |
| accLo | input | 8 | Low accumulator byte before adjustment |
| accHi | input | 8 | High accumulator byte before adjustment |
| auxIn | input | 1 | Incoming auxiliary-carry flag |
| carryIn | input | 1 | Incoming carry flag |
| outValid | output | 1 | The result outputs carry a new result |
| resLo | output | 8 | Adjusted low accumulator byte |
| resHi | output | 8 | Adjusted high accumulator byte |
| auxOut | output | 1 | New auxiliary-carry flag |
| carryOut | output | 1 | New carry flag |

## Verification
Every result of this block (both bytes, both flags and outValid) is due exactly one clock after the edge that samples inValid high, because only one register lies between the inputs and the outputs. The bench sets the inputs at a falling edge. It reads the outputs at the next falling edge, which comes after the single capturing rising edge, so the vector table runs back to back, with one result checked every cycle. The hold check and the idle check read the outputs at that same point, one cycle after inValid drops. The reset check reads them while rstN is still low.

// File: rtl/bcdadj_pkg.sv
package bcdadj_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam int unsigned OP_W   = 2;
  localparam logic [NIB_W-1:0]  DIGIT_MAX  = NIB_W'(9);
  localparam logic [BYTE_W-1:0] PACKED_MAX = 8'h99;
  localparam logic [BYTE_W-1:0] LOW_CORR   = 8'h06;
  localparam logic [BYTE_W-1:0] HIGH_CORR  = 8'h60;

  // bit 1: unpacked form, bit 0: subtract
  typedef enum logic [OP_W-1:0] {
    OP_PACK_ADD = 2'b00,
    OP_PACK_SUB = 2'b01,
    OP_UNPK_ADD = 2'b10,
    OP_UNPK_SUB = 2'b11
  } adjOp_e;

  typedef struct packed {
    logic subtract;
    logic unpacked;
    logic lowFix;
    logic highFix;
  } adjStrobes_t;
endpackage

// File: rtl/bcdadj_ctrl.sv
module bcdadj_ctrl
  import bcdadj_pkg::*;
(
  input  logic [OP_W-1:0]   opSel,
  input  logic [BYTE_W-1:0] accLo,
  input  logic              auxIn,
  input  logic              carryIn,
  output adjStrobes_t       strobes
);
  logic [NIB_W-1:0] lowNib;
  logic             lowBig;
  logic             lowFix;
  logic             lowCarry;
  logic [NIB_W:0]   highMid;
  logic             highFixAdd;
  logic             highFixSub;
  adjOp_e           op;

  always_comb begin
    op       = adjOp_e'(opSel);
    lowNib   = accLo[NIB_W-1:0];
    lowBig   = lowNib > DIGIT_MAX;
    lowFix   = lowBig | auxIn;                           // R1 R3 R5 R6
    // adding 6 to a nibble of 10..15 always carries into the high nibble
    lowCarry = lowFix & lowBig;
    highMid  = {1'b0, accLo[BYTE_W-1:NIB_W]} + {{NIB_W{1'b0}}, lowCarry};
    highFixAdd = (highMid > {1'b0, DIGIT_MAX}) | carryIn; // R2
    highFixSub = (accLo > PACKED_MAX) | carryIn;          // R3

    strobes.subtract = (op == OP_PACK_SUB) || (op == OP_UNPK_SUB);
    strobes.unpacked = (op == OP_UNPK_ADD) || (op == OP_UNPK_SUB);
    strobes.lowFix   = lowFix;
    unique case (op)
      OP_PACK_ADD: strobes.highFix = highFixAdd;
      OP_PACK_SUB: strobes.highFix = highFixSub;
      default:     strobes.highFix = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcdadj_datapath.sv
module bcdadj_datapath
  import bcdadj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] accLo,
  input  logic [BYTE_W-1:0] accHi,
  input  adjStrobes_t       strobes,
  output logic              outValid,
  output logic [BYTE_W-1:0] resLo,
  output logic [BYTE_W-1:0] resHi,
  output logic              auxOut,
  output logic              carryOut
);
  logic [BYTE_W-1:0] corr;
  logic [BYTE_W-1:0] loRaw;
  logic [BYTE_W-1:0] nextLo;
  logic [BYTE_W-1:0] hiStep;
  logic [BYTE_W-1:0] nextHi;
  logic              nextAf;
  logic              nextCf;

  always_comb begin
    corr = (strobes.lowFix ? LOW_CORR : '0) | (strobes.highFix ? HIGH_CORR : '0);
    loRaw  = strobes.subtract ? (accLo - corr) : (accLo + corr);
    nextLo = strobes.unpacked ? {{NIB_W{1'b0}}, loRaw[NIB_W-1:0]} : loRaw;
    hiStep = {{(BYTE_W-1){1'b0}}, strobes.unpacked & strobes.lowFix};
    nextHi = strobes.subtract ? (accHi - hiStep) : (accHi + hiStep);
    nextAf = strobes.lowFix;
    nextCf = strobes.unpacked ? strobes.lowFix : strobes.highFix;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          resLo    <= '0;
          resHi    <= '0;
          auxOut   <= 1'b0;
          carryOut <= 1'b0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            resLo    <= nextLo;
            resHi    <= nextHi;
            auxOut   <= nextAf;
            carryOut <= nextCf;
          end
        end
      end

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid); // R7
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid); // R7
      AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> ($stable(resLo) && $stable(resHi) && $stable(auxOut) && $stable(carryOut))); // R7
      AST_UNPACKED_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && strobes.unpacked) |=> (resLo[BYTE_W-1:NIB_W] == '0)); // R5
      AST_UNPACKED_FLAGS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && strobes.unpacked) |=> (auxOut == carryOut)); // R6
      AST_PACKED_HI_PASS: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !strobes.unpacked) |=> (resHi == $past(accHi))); // R4
    end else begin : g_comb
      always_comb begin
        outValid = inValid;
        resLo    = nextLo;
        resHi    = nextHi;
        auxOut   = nextAf;
        carryOut = nextCf;
      end
    end
  endgenerate
endmodule

// File: rtl/bcdadj_top.sv
module bcdadj_top
  import bcdadj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  input  logic [7:0]  accLo,
  input  logic [7:0]  accHi,
  input  logic        auxIn,
  input  logic        carryIn,
  output logic        outValid,
  output logic [7:0]  resLo,
  output logic [7:0]  resHi,
  output logic        auxOut,
  output logic        carryOut
);
  adjStrobes_t strobes;

  bcdadj_ctrl u_ctrl (
    .opSel   (opSel),
    .accLo   (accLo),
    .auxIn   (auxIn),
    .carryIn (carryIn),
    .strobes (strobes)
  );

  bcdadj_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .accLo    (accLo),
    .accHi    (accHi),
    .strobes  (strobes),
    .outValid (outValid),
    .resLo    (resLo),
    .resHi    (resHi),
    .auxOut   (auxOut),
    .carryOut (carryOut)
  );
endmodule

// File: tb/tb_bcdadj_top.sv
module tb_bcdadj_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;
  // {op, accLo, accHi, auxIn, carryIn, expLo, expHi, expAf, expCf}
  localparam logic [37:0] VECS [NVEC] = '{
    {2'd0, 8'h8E, 8'h00, 1'b0, 1'b0, 8'h94, 8'h00, 1'b1, 1'b0}, // R1
    {2'd0, 8'hD1, 8'h00, 1'b1, 1'b0, 8'h37, 8'h00, 1'b1, 1'b1}, // R2
    {2'd0, 8'h45, 8'h12, 1'b0, 1'b0, 8'h45, 8'h12, 1'b0, 1'b0}, // R4
    {2'd0, 8'h45, 8'h00, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b0, 1'b1}, // R2
    {2'd0, 8'hA0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}, // R2
    {2'd0, 8'hFA, 8'h00, 1'b0, 1'b0, 8'h60, 8'h00, 1'b1, 1'b1}, // R2
    {2'd0, 8'h99, 8'h00, 1'b0, 1'b0, 8'h99, 8'h00, 1'b0, 1'b0}, // R4
    {2'd1, 8'h2F, 8'h00, 1'b0, 1'b0, 8'h29, 8'h00, 1'b1, 1'b0}, // R3
    {2'd1, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h34, 8'h00, 1'b1, 1'b1}, // R3
    {2'd1, 8'h15, 8'h00, 1'b0, 1'b1, 8'hB5, 8'h00, 1'b0, 1'b1}, // R3
    {2'd1, 8'h33, 8'h77, 1'b0, 1'b0, 8'h33, 8'h77, 1'b0, 1'b0}, // R4
    {2'd1, 8'h03, 8'h00, 1'b1, 1'b0, 8'hFD, 8'h00, 1'b1, 1'b0}, // R3
    {2'd2, 8'h6E, 8'h00, 1'b0, 1'b0, 8'h04, 8'h01, 1'b1, 1'b1}, // R5
    {2'd2, 8'h35, 8'h02, 1'b0, 1'b0, 8'h05, 8'h02, 1'b0, 1'b0}, // R5
    {2'd2, 8'h32, 8'h04, 1'b1, 1'b0, 8'h08, 8'h05, 1'b1, 1'b1}, // R5
    {2'd2, 8'h39, 8'hFF, 1'b0, 1'b1, 8'h09, 8'hFF, 1'b0, 1'b0}, // R5
    {2'd3, 8'h3F, 8'h05, 1'b0, 1'b0, 8'h09, 8'h04, 1'b1, 1'b1}, // R6
    {2'd3, 8'h02, 8'h00, 1'b1, 1'b0, 8'h0C, 8'hFF, 1'b1, 1'b1}, // R6
    {2'd3, 8'h37, 8'h03, 1'b0, 1'b0, 8'h07, 8'h03, 1'b0, 1'b0}  // R6
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] opSel = '0;
  logic [7:0] accLo = '0;
  logic [7:0] accHi = '0;
  logic auxIn = 1'b0;
  logic carryIn = 1'b0;
  logic outValid;
  logic [7:0] resLo;
  logic [7:0] resHi;
  logic auxOut;
  logic carryOut;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcdadj_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .accLo(accLo), .accHi(accHi), .auxIn(auxIn), .carryIn(carryIn),
    .outValid(outValid), .resLo(resLo), .resHi(resHi),
    .auxOut(auxOut), .carryOut(carryOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] op, input logic [7:0] lo,
                                  input logic af, input logic cf);
    if (op[1]) return op[0] ? "R6 unpacked-sub" : "R5 unpacked-add";
    if (lo[3:0] <= 4'd9 && !af && lo <= 8'h99 && !cf) return "R4 no-fix";
    if (op[0]) return "R3 packed-sub";
    return "R1/R2 packed-add";
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk);
    check("R8 reset outValid", 32'(outValid), 0);
    check("R8 reset resLo", 32'(resLo), 0);
    check("R8 reset resHi", 32'(resHi), 0);
    check("R8 reset flags", {30'd0, auxOut, carryOut}, 0);
    rstN = 1'b1;

    // table walk, back to back: each result due one rising edge after drive
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      if (i > 0) begin
        string t;
        t = reqOf(VECS[i-1][37:36], VECS[i-1][35:28], VECS[i-1][19], VECS[i-1][18]);
        check({t, " valid"}, 32'(outValid), 1);
        check({t, " lo"}, 32'(resLo), 32'(VECS[i-1][17:10]));
        check({t, " hi"}, 32'(resHi), 32'(VECS[i-1][9:2]));
        check({t, " af"}, 32'(auxOut), 32'(VECS[i-1][1]));
        check({t, " cf"}, 32'(carryOut), 32'(VECS[i-1][0]));
      end
      inValid = 1'b1;
      opSel   = VECS[i][37:36];
      accLo   = VECS[i][35:28];
      accHi   = VECS[i][27:20];
      auxIn   = VECS[i][19];
      carryIn = VECS[i][18];
    end
    @(negedge clk);
    check("R6 last lo", 32'(resLo), 32'(VECS[NVEC-1][17:10]));
    check("R6 last hi", 32'(resHi), 32'(VECS[NVEC-1][9:2]));

    // R7: idle input with new data must not disturb outputs
    inValid = 1'b0;
    opSel = 2'd0; accLo = 8'hFF; accHi = 8'hAA; auxIn = 1'b1; carryIn = 1'b1;
    @(negedge clk);
    check("R7 idle outValid", 32'(outValid), 0);
    check("R7 hold lo", 32'(resLo), 8'h07);
    check("R7 hold hi", 32'(resHi), 8'h03);
    check("R7 hold flags", {30'd0, auxOut, carryOut}, 0);

    // R7: single valid pulse, result one cycle later then valid drops
    inValid = 1'b1; opSel = 2'd0; accLo = 8'h59; accHi = 8'h00; auxIn = 1'b0; carryIn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 pulse valid", 32'(outValid), 1);
    check("R1 59h adj", 32'(resLo), 8'h59);
    @(negedge clk);
    check("R7 pulse valid drop", 32'(outValid), 0);

    // R5: AH wrap at FFh with a fix
    inValid = 1'b1; opSel = 2'd2; accLo = 8'h0B; accHi = 8'hFF; auxIn = 1'b0; carryIn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R5 wrap lo", 32'(resLo), 8'h01);
    check("R5 wrap hi", 32'(resHi), 8'h00);

    // R8: asynchronous reset in mid-run clears outputs
    rstN = 1'b0;
    #1;
    check("R8 async lo", 32'(resLo), 0);
    check("R8 async valid", 32'(outValid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule